// File: doc/BRIEF.md
# Reloading Interval Timer Channel

This block is one channel of a down-counting interval timer. It runs on the system clock and advances its counter only in cycles where an external prescaler raises a one-cycle count tick. Software supplies single-cycle strobes to start and to stop the channel. It also writes a 16-bit reload value and a configuration bit that requests an interrupt at the moment counting begins. The channel reports whether it is enabled, shows its live count, and emits a one-cycle interrupt pulse.

A start strobe does not begin counting at once. It only enables the channel. The counter keeps whatever value it held until the next count tick. On that tick the reload value is copied in and the start moment is defined, so counting can begin up to one tick period after the strobe. If the configuration bit is set, this start moment also raises the interrupt. From then on each tick lowers the count by one. The tick that arrives while the count is zero reloads the counter and raises the interrupt, so interrupts are spaced by reload value plus one ticks.

The control path is a three-state machine. IDLE is the disabled state. ARMED means enabled and waiting for the first tick. RUN means counting. The transitions are:
- start (IDLE to ARMED, on a start strobe with no stop strobe);
- launch (ARMED to RUN, on a tick with no stop strobe; the counter loads and the optional start interrupt fires);
- abort (ARMED to IDLE, on a stop strobe; the pending start is dropped);
- halt (RUN to IDLE, on a stop strobe; the counter freezes);
- step (RUN to RUN, on a tick; the counter decrements, or reloads with an interrupt when it is at zero).

Top module: `reload_interval_timer`

## Requirements
- R1: After reset the count reads 0xFFFF, `enabled` is 0, `irq` is 0, the stored reload value is 0x0000 and the start-interrupt configuration bit is 0.
- R2: A `start_wr` strobe while disabled sets `enabled` from the next cycle on. The count keeps its previous value until a tick arrives.
- R3: The first tick that arrives while the channel is enabled and not yet counting loads the stored reload value into the count. A tick in the same cycle as the `start_wr` strobe is not used for this.
- R4: The launch tick produces an `irq` pulse in the following cycle when the start-interrupt configuration bit is 1, and no pulse when it is 0.
- R5: While counting, a tick with a nonzero count lowers the count by exactly one in the next cycle. Cycles without a tick leave the count unchanged.
- R6: While counting, a tick with a count of zero reloads the stored value and raises `irq` in the next cycle. Interrupts are therefore spaced by reload value plus one ticks, and a reload value of 0 gives an interrupt on every tick.
- R7: `irq` is high only in the cycle directly after a tick, for one cycle per tick.
- R8: A `stop_wr` strobe clears `enabled` in the next cycle and freezes the count. It wins over a same-cycle tick or `start_wr`, and it discards a pending launch. No reload or `irq` occurs while disabled.
- R9: A `data_wr` strobe only updates the stored reload value. A running count is not disturbed, and the new value is used at the next reload. A reload in the same cycle as the write uses the value held before the write.
- R10: A `start_wr` strobe while already enabled has no effect on the count or the state.
- R11: A `cfg_wr` strobe stores `cfg_start_irq` as the start-interrupt configuration bit used by R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable from the prescaler |
| start_wr | input | 1 | Software strobe: enable the channel |
| stop_wr | input | 1 | Software strobe: disable the channel |
| data_wr | input | 1 | Software strobe: store `data_in` as the reload value |
| data_in | input | 16 | Reload value to store |
| cfg_wr | input | 1 | Software strobe: store `cfg_start_irq` |
| cfg_start_irq | input | 1 | 1 requests an interrupt at the launch tick |
| enabled | output | 1 | Channel enabled (ARMED or RUN) |
| count | output | 16 | Live counter value |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that every input is a known value on each rising edge. They also assume that the software strobes and the tick each stand for one event per cycle in which they are high, so two ticks in a row are two separate count steps. The bench changes all inputs two time units after a falling edge, so each input holds steady across the edge that samples it. The directed part covers every transition of the state machine, including the cases where a stop strobe meets a tick or a start strobe in the same cycle. The random part keeps stop strobes rare and reload values small, so the count reaches zero and reloads many times between stops, and it compares the outputs against the reference model on every cycle.

// File: rtl/rit_pkg.sv
package rit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } rit_state_e;
endpackage

// File: rtl/rit_regs.sv
// Software-written reload value and start-interrupt configuration bit.
module rit_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [CNT_W-1:0] data_in,
    input  logic             cfg_wr,
    input  logic             cfg_start_irq,
    output logic [CNT_W-1:0] reload_q,
    output logic             start_irq_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q    <= '0;
            start_irq_q <= 1'b0;
        end else begin
            if (data_wr) reload_q    <= data_in;
            if (cfg_wr)  start_irq_q <= cfg_start_irq;
        end
    end
endmodule

// File: rtl/rit_counter.sv
// Down counter that loads on command and reports zero.
module rit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_load,
    input  logic             do_dec,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_zero
);
    localparam logic [CNT_W-1:0] RESET_VAL = '1;
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RESET_VAL;
        end else if (do_load) begin
            cnt_q <= reload_val;
        end else if (do_dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/rit_ctrl.sv
// Channel state machine: IDLE, ARMED, RUN.
module rit_ctrl
    import rit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_wr,
    input  logic stop_wr,
    input  logic tick,
    input  logic cnt_zero,
    input  logic start_irq_en,
    output logic enabled,
    output logic running,
    output logic do_load,
    output logic do_dec,
    output logic irq
);
    rit_state_e state_q, state_d;
    logic       irq_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic; stop has priority over start and tick
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_wr && !stop_wr) state_d = ST_ARMED;
            ST_ARMED: begin
                if (stop_wr)   state_d = ST_IDLE;
                else if (tick) state_d = ST_RUN;
            end
            ST_RUN:   if (stop_wr) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        do_load = 1'b0;
        do_dec  = 1'b0;
        irq_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARMED: begin
                if (tick && !stop_wr) begin
                    do_load = 1'b1;
                    irq_d   = start_irq_en;
                end
            end
            ST_RUN: begin
                if (tick && !stop_wr) begin
                    if (cnt_zero) begin
                        do_load = 1'b1;
                        irq_d   = 1'b1;
                    end else begin
                        do_dec  = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_d;
    end

    assign enabled = (state_q != ST_IDLE);
    assign running = (state_q == ST_RUN);

    AST_START_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && start_wr && !stop_wr) |=> enabled); // R2
    AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> !enabled); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |-> !irq); // R8
    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick)); // R7
    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start_wr && !stop_wr) |=> running); // R10
endmodule

// File: rtl/reload_interval_timer.sv
module reload_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start_wr,
    input  logic             stop_wr,
    input  logic             data_wr,
    input  logic [CNT_W-1:0] data_in,
    input  logic             cfg_wr,
    input  logic             cfg_start_irq,
    output logic             enabled,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    logic [CNT_W-1:0] reload_q;
    logic             start_irq_q;
    logic             cnt_zero;
    logic             do_load;
    logic             do_dec;
    logic             running;

    rit_regs #(.CNT_W(CNT_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .data_wr       (data_wr),
        .data_in       (data_in),
        .cfg_wr        (cfg_wr),
        .cfg_start_irq (cfg_start_irq),
        .reload_q      (reload_q),
        .start_irq_q   (start_irq_q)
    );

    rit_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_wr     (start_wr),
        .stop_wr      (stop_wr),
        .tick         (tick),
        .cnt_zero     (cnt_zero),
        .start_irq_en (start_irq_q),
        .enabled      (enabled),
        .running      (running),
        .do_load      (do_load),
        .do_dec       (do_dec),
        .irq          (irq)
    );

    rit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .do_load    (do_load),
        .do_dec     (do_dec),
        .reload_val (reload_q),
        .cnt_q      (count),
        .cnt_zero   (cnt_zero)
    );

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R5
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !stop_wr && count != '0) |=> count == $past(count) - CNT_W'(1)); // R5
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !stop_wr && count == '0) |=> (irq && count == $past(reload_q))); // R6
    AST_LAUNCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !running && tick && !stop_wr) |=> (running && count == $past(reload_q))); // R3
    AST_LAUNCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && !running && tick && !stop_wr) |=> irq == $past(start_irq_q)); // R4
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> $stable(count)); // R8
endmodule

// File: tb/tb_reload_interval_timer.sv
module tb_reload_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, start_wr = 1'b0, stop_wr = 1'b0;
    logic        data_wr = 1'b0, cfg_wr = 1'b0, cfg_start_irq = 1'b0;
    logic [15:0] data_in = 16'h0;
    logic        enabled, irq;
    logic [15:0] count;

    int    total = 0, bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state: 0 idle, 1 armed, 2 run
    int m_state = 0, m_count = 65535, m_data = 0, m_mode = 0, m_irq = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    reload_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start_wr(start_wr),
        .stop_wr(stop_wr), .data_wr(data_wr), .data_in(data_in),
        .cfg_wr(cfg_wr), .cfg_start_irq(cfg_start_irq),
        .enabled(enabled), .count(count), .irq(irq)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_count = 65535; m_data = 0; m_mode = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            if (m_state == 0) begin
                if (start_wr && !stop_wr) m_state = 1;
            end else if (stop_wr) begin
                m_state = 0;
            end else if (tick) begin
                if (m_state == 1) begin
                    m_count = m_data; m_irq = m_mode; m_state = 2;
                end else if (m_count == 0) begin
                    m_count = m_data; m_irq = 1;
                end else begin
                    m_count = m_count - 1;
                end
            end
            if (data_wr) m_data = data_in;
            if (cfg_wr)  m_mode = cfg_start_irq;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "model enabled", int'(enabled), int'(m_state != 0));
            chk(cur_req, "model count", int'(count), m_count);
            chk(cur_req, "model irq", int'(irq), m_irq);
        end
    end

    task automatic cyc();
        @(negedge clk);
        #2;
    endtask

    // one-cycle stimulus; outputs reflect it when the task returns
    task automatic drive(input logic t, input logic s, input logic p,
                         input logic dw, input logic [15:0] dv,
                         input logic cw, input logic cv);
        cyc();
        tick = t; start_wr = s; stop_wr = p;
        data_wr = dw; data_in = dv; cfg_wr = cw; cfg_start_irq = cv;
        cyc();
        tick = 0; start_wr = 0; stop_wr = 0; data_wr = 0; cfg_wr = 0;
    endtask

    task automatic do_tick();  drive(1, 0, 0, 0, 16'h0, 0, 0); endtask
    task automatic do_start(); drive(0, 1, 0, 0, 16'h0, 0, 0); endtask
    task automatic do_stop();  drive(0, 0, 1, 0, 16'h0, 0, 0); endtask
    task automatic do_data(input logic [15:0] v); drive(0, 0, 0, 1, v, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        cur_req = "R1";
        chk("R1", "count", int'(count), 65535);
        chk("R1", "enabled", int'(enabled), 0);
        chk("R1", "irq", int'(irq), 0);

        // R2 enable holds count until a tick
        cur_req = "R2";
        do_start();
        chk("R2", "enabled", int'(enabled), 1);
        chk("R2", "count held", int'(count), 65535);
        repeat (3) cyc();
        chk("R2", "count held later", int'(count), 65535);

        // R3 launch loads reset reload value 0; R4 no start irq with config 0
        cur_req = "R3";
        do_tick();
        chk("R3", "launch load", int'(count), 0);
        chk("R4", "no start irq", int'(irq), 0);

        // R6 reload value 0 gives irq on every tick
        cur_req = "R6";
        n = 0;
        for (int i = 0; i < 5; i++) begin
            do_tick();
            if (irq) n++;
        end
        chk("R6", "irq per tick", n, 5);

        // R8 stop freezes
        cur_req = "R8";
        do_stop();
        chk("R8", "enabled", int'(enabled), 0);
        n = 0;
        for (int i = 0; i < 3; i++) begin
            do_tick();
            if (irq) n++;
        end
        chk("R8", "count frozen", int'(count), 0);
        chk("R8", "no irq idle", n, 0);

        // R3 tick in the start cycle is not the launch tick
        cur_req = "R3";
        do_data(16'd5);
        drive(1, 1, 0, 0, 16'h0, 0, 0);
        chk("R3", "same-cycle tick unused", int'(count), 0);
        chk("R3", "enabled", int'(enabled), 1);
        do_tick();
        chk("R3", "load 5", int'(count), 5);

        // R5 decrement and hold
        cur_req = "R5";
        do_tick();
        chk("R5", "decrement", int'(count), 4);
        repeat (4) cyc();
        chk("R5", "hold", int'(count), 4);

        // R10 start while enabled ignored
        cur_req = "R10";
        do_start();
        chk("R10", "count unchanged", int'(count), 4);
        do_tick();
        chk("R10", "still counting", int'(count), 3);

        // R9 write while running takes effect at the next reload
        cur_req = "R9";
        do_data(16'd2);
        chk("R9", "count undisturbed", int'(count), 3);
        repeat (3) do_tick();
        chk("R9", "reached zero", int'(count), 0);
        do_tick();
        chk("R9", "new reload", int'(count), 2);
        chk("R6", "wrap irq", int'(irq), 1);
        cyc();
        chk("R7", "irq one cycle", int'(irq), 0);

        // R6 period = reload + 1 ticks
        cur_req = "R6";
        n = 0;
        for (int i = 0; i < 9; i++) begin
            do_tick();
            if (irq) n++;
        end
        chk("R6", "period 3", n, 3);

        // R8 stop wins over same-cycle tick
        cur_req = "R8";
        drive(1, 0, 1, 0, 16'h0, 0, 0);
        chk("R8", "stop+tick count", int'(count), 2);
        chk("R8", "stop+tick enabled", int'(enabled), 0);

        // R11 config write; R8 pending launch discarded
        cur_req = "R11";
        drive(0, 0, 0, 0, 16'h0, 1, 1);
        do_data(16'd7);
        do_start();
        do_stop();
        do_tick();
        chk("R8", "discarded launch count", int'(count), 2);
        chk("R8", "discarded launch irq", int'(irq), 0);

        // R4 start irq with config 1
        cur_req = "R4";
        do_start();
        do_tick();
        chk("R4", "start irq", int'(irq), 1);
        chk("R11", "load 7", int'(count), 7);

        // R8 stop and start together while idle stay idle
        cur_req = "R8";
        do_stop();
        drive(0, 1, 1, 0, 16'h0, 0, 0);
        chk("R8", "stop beats start", int'(enabled), 0);

        // R9 reload in the same cycle as a write uses the old value
        cur_req = "R9";
        do_data(16'd0);
        do_start();
        do_tick();
        drive(1, 0, 0, 1, 16'd9, 0, 0);
        chk("R9", "same-cycle reload old value", int'(count), 0);
        do_tick();
        chk("R9", "next reload new value", int'(count), 9);

        // random phase, model comparison each cycle covers R5 R6 R9
        cur_req = "R5";
        for (int i = 0; i < 4000; i++) begin
            cyc();
            tick     = ($urandom_range(0, 2) == 0);
            start_wr = ($urandom_range(0, 49) == 0);
            stop_wr  = ($urandom_range(0, 299) == 0);
            data_wr  = ($urandom_range(0, 19) == 0);
            data_in  = 16'($urandom_range(0, 12));
            cfg_wr   = ($urandom_range(0, 99) == 0);
            cfg_start_irq = ($urandom_range(0, 1) == 1);
        end
        cyc();
        tick = 0; start_wr = 0; stop_wr = 0; data_wr = 0; cfg_wr = 0;
        repeat (3) cyc();

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule